// File: doc/BRIEF.md
# Varint Byte-Stream Encoder

This block turns unsigned integers into a compact byte stream. Each value is cut into 7-bit groups, and the groups go out least significant first. The top bit of every byte says whether another byte of the same value follows. The encoder writes the fewest bytes that hold the value, so the last byte of a value is never an all-zero group unless the value itself is zero. Integers come in on a valid/ready interface. Bytes leave one per cycle on a second valid/ready interface, together with a flag that marks the final byte of each integer.

A second input mode takes a gate triple: a left-hand literal and two right-hand literals. The block checks the ordering rule (left-hand strictly above the first right-hand, first right-hand at or above the second). When the ordering holds, it emits the two differences back to back: left minus first right, then first right minus second right. When the ordering fails, it raises a one-cycle error pulse and emits nothing.

Top module: `varint_byte_emitter`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and enc_err is 0.
- R2: Each output byte carries the next 7-bit group of the value in bits 6:0, lowest group first. Bit 7 is 1 when more bytes of the same integer follow and 0 on its last byte.
- R3: The encoding has minimum length. Zero is the single byte 0x00. For any value above 127, the last byte has a non-zero low group.
- R4: The following encodings are exact. 127 gives 7f. 128 gives 80 01. 258 gives 82 02. 16383 gives ff 7f. 16387 gives 83 80 01. 2^28+7 gives 87 80 80 80 01. 0xFFFFFFFF gives ff ff ff ff 0f.
- R5: A 32-bit value never produces more than 5 bytes.
- R6: While out_valid is 1 and out_ready is 0, out_byte and out_end hold their values.
- R7: From the cycle after an integer is accepted until its final byte (final byte of the second difference in triple mode) has been taken, in_ready is 0. in_ready is 1 in the cycle after that final byte is taken.
- R8: With in_triple=1 and a well-ordered triple, the output is the encoding of in_value-in_rhs0, then the encoding of in_rhs0-in_rhs1. out_end is 1 on the last byte of each of the two.
- R9: With in_triple=1 and either in_value<=in_rhs0 or in_rhs0<in_rhs1, enc_err is 1 for exactly the one cycle after acceptance, no byte is emitted, and in_ready stays 1. Equal right-hand literals are legal and give a 0x00 second difference.
- R10: out_end is 1 exactly on bytes whose bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input item offered |
| in_ready | output | 1 | Encoder can take an item |
| in_triple | input | 1 | 0: encode in_value; 1: treat in_value, in_rhs0, in_rhs1 as a gate triple |
| in_value | input | VAL_W | Value to encode, or left-hand literal in triple mode |
| in_rhs0 | input | VAL_W | First right-hand literal (triple mode) |
| in_rhs1 | input | VAL_W | Second right-hand literal (triple mode) |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | GRP_W+1 | Continuation flag in the MSB, 7-bit group below |
| out_end | output | 1 | Current byte is the last of its integer |
| enc_err | output | 1 | One-cycle pulse on a badly ordered triple |

## Verification
The bench builds the encoder with its defaults, VAL_W=32 and GRP_W=7. With these values the longest sequence is five bytes, and the fifth byte carries only the top four value bits. The all-ones value therefore reaches both the length limit and a partly filled last group. The boundary values either side of each 7-bit group edge are within reach at this width, as are triples whose differences span several bytes. Random consumer stalls exercise the hold and handshake rules.

// File: rtl/varint_byte_emitter.sv
module varint_byte_emitter #(
  parameter int VAL_W = 32,
  parameter int GRP_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_triple,
  input  logic [VAL_W-1:0]   in_value,
  input  logic [VAL_W-1:0]   in_rhs0,
  input  logic [VAL_W-1:0]   in_rhs1,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [GRP_W:0]     out_byte,
  output logic               out_end,
  output logic               enc_err
);
  localparam int BYTE_W = GRP_W + 1;

  logic             busy;
  logic             have_pend;
  logic [VAL_W-1:0] rem;
  logic [VAL_W-1:0] pend;
  logic             err_q;

  logic more, take, acc, order_ok;

  assign more      = |(rem >> GRP_W);
  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_byte  = {more, rem[GRP_W-1:0]};
  assign out_end   = !more;
  assign enc_err   = err_q;
  assign take      = busy && out_ready;
  assign acc       = in_valid && !busy;
  assign order_ok  = (in_value > in_rhs0) && (in_rhs0 >= in_rhs1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      have_pend <= 1'b0;
      rem       <= '0;
      pend      <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (acc) begin
        if (!in_triple) begin
          rem  <= in_value;
          busy <= 1'b1;
        end else if (order_ok) begin
          rem       <= in_value - in_rhs0;
          pend      <= in_rhs0 - in_rhs1;
          have_pend <= 1'b1;
          busy      <= 1'b1;
        end else begin
          err_q <= 1'b1;
        end
      end else if (take) begin
        if (more) begin
          rem <= rem >> GRP_W;
        end else if (have_pend) begin
          rem       <= pend;
          have_pend <= 1'b0;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  logic unused_w;
  assign unused_w = (BYTE_W == 0);
endmodule

// File: rtl/varint_emitter_chk.sv
module varint_emitter_chk #(
  parameter int VAL_W = 32,
  parameter int GRP_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [GRP_W:0] out_byte,
  input logic           out_end,
  input logic           enc_err
);
  localparam int MAX_BYTES = (VAL_W + GRP_W - 1) / GRP_W;
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic [CNT_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (out_valid && out_ready) idx <= out_byte[GRP_W] ? idx + 1'b1 : '0;
  end

  // R6
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_end));

  // R7
  no_accept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R9
  err_without_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err |-> in_ready && !out_valid);

  // R5
  max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> idx < CNT_W'(MAX_BYTES));

  // R3
  minimal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_byte[GRP_W] && idx != '0 |-> out_byte[GRP_W-1:0] != '0);

  // R9
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err |=> !enc_err);
endmodule

bind varint_byte_emitter varint_emitter_chk #(.VAL_W(VAL_W), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .out_end(out_end), .enc_err(enc_err)
);

// File: tb/test_varint_byte_emitter.sv
module test_varint_byte_emitter;
  localparam int VAL_W = 32;
  localparam int GRP_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_triple = 1'b0, out_ready = 1'b0;
  logic [VAL_W-1:0] in_value = '0, in_rhs0 = '0, in_rhs1 = '0;
  logic in_ready, out_valid, out_end, enc_err;
  logic [GRP_W:0] out_byte;

  always #2 clk = ~clk;

  varint_byte_emitter #(.VAL_W(VAL_W), .GRP_W(GRP_W)) i_varint_byte_emitter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_triple(in_triple), .in_value(in_value), .in_rhs0(in_rhs0), .in_rhs1(in_rhs1),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_end(out_end), .enc_err(enc_err)
  );

  int checks = 0;
  int fails = 0;
  logic [8:0] expq[$];
  int stall_mode = 0;
  logic mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_enc(input logic [VAL_W-1:0] v);
    longint unsigned r = v;
    do begin
      int b = int'(r % 128);
      r = r / 128;
      if (r != 0) b += 128;
      expq.push_back({r == 0, b[7:0]});
    end while (r != 0);
  endtask

  always @(posedge clk) begin
    if (stall_mode == 0) out_ready <= 1'b1;
    else out_ready <= ($urandom_range(0, 3) != 0);
  end

  logic prev_stall = 1'b0;
  logic [GRP_W:0] prev_byte = '0;
  logic prev_end = 1'b0;
  logic want_ready = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (want_ready) begin
        // R7: free again the cycle after the final byte is taken
        check(in_ready == 1'b1, "R7 ready after last", in_ready, 1);
        want_ready = 1'b0;
      end
      if (prev_stall)
        // R6
        check(out_valid && out_byte == prev_byte && out_end == prev_end,
              "R6 hold", out_byte, prev_byte);
      if (out_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R2 unexpected byte", out_byte, 0);
        end else if (out_ready) begin
          logic [8:0] e;
          e = expq.pop_front();
          // R2 R3 R4 R8
          check(out_byte == e[7:0], "R2 byte value", out_byte, e[7:0]);
          // R10
          check(out_end == e[8], "R10 end flag", out_end, e[8]);
          if (e[8] && expq.size() == 0) want_ready = 1'b1;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_byte = out_byte;
      prev_end = out_end;
    end
  end

  task automatic wait_drain();
    int n = 0;
    while ((expq.size() != 0 || !in_ready) && n < 1000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic send(input bit tri_m, input logic [VAL_W-1:0] v,
                      input logic [VAL_W-1:0] a, input logic [VAL_W-1:0] b);
    bit bad;
    bad = tri_m && !(v > a && a >= b);
    if (!tri_m) push_enc(v);
    else if (!bad) begin
      push_enc(v - a);
      push_enc(a - b);
    end
    in_triple = tri_m; in_value = v; in_rhs0 = a; in_rhs1 = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (bad) begin
      // R9
      check(enc_err == 1'b1, "R9 err pulse", enc_err, 1);
      check(!out_valid && in_ready, "R9 no bytes", out_valid, 0);
      @(negedge clk);
      check(enc_err == 1'b0, "R9 err one cycle", enc_err, 0);
      check(!out_valid, "R9 still no bytes", out_valid, 0);
    end else begin
      // R7
      check(in_ready == 1'b0, "R7 busy after accept", in_ready, 0);
      wait_drain();
    end
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    // R1
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(enc_err == 1'b0, "R1 enc_err", enc_err, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = pass;
      // R3 zero, R4 table, R5 all-ones
      send(0, 32'd0, '0, '0);
      send(0, 32'd127, '0, '0);
      send(0, 32'd128, '0, '0);
      send(0, 32'd258, '0, '0);
      send(0, 32'd16383, '0, '0);
      send(0, 32'd16387, '0, '0);
      send(0, 32'h1000_0007, '0, '0);
      send(0, 32'hFFFF_FFFF, '0, '0);
      // R8
      send(1, 32'd20, 32'd10, 32'd10);
      send(1, 32'd300, 32'd100, 32'd3);
      send(1, 32'hFFFF_FFFF, 32'd1, 32'd0);
      // R9
      send(1, 32'd10, 32'd10, 32'd2);
      send(1, 32'd5, 32'd9, 32'd1);
      send(1, 32'd20, 32'd5, 32'd8);
      for (int k = 0; k < 40; k++) send(0, $urandom() >> $urandom_range(0, 31), '0, '0);
    end
    // R5: all-ones gives exactly 5 bytes
    stall_mode = 0;
    begin
      int nb = 0;
      in_triple = 1'b0; in_value = 32'hFFFF_FFFF; in_valid = 1'b1;
      push_enc(32'hFFFF_FFFF);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      while (out_valid && nb < 10) begin
        nb++;
        @(negedge clk);
      end
      check(nb == 5, "R5 length", nb, 5);
      wait_drain();
    end
    check(expq.size() == 0, "R2 all bytes seen", expq.size(), 0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule